// File: doc/BRIEF.md
# Tightly Coupled Data Memory Port Arbiter

This block sits in front of a single-ported, tightly coupled data memory and decides, cycle by cycle, who drives the memory's address, chip-select and sequential-hint lines: the processor's load/store request or a DMA engine. DMA always wins. A processor request that arrives while DMA owns the port is stalled through a combinational stall output; the processor holds its request, and it is performed in the first cycle in which DMA has let go.

The block regenerates the sequential hint itself. A processor access is marked sequential only when the processor asks for it, the previous port cycle was a processor access, and the address is exactly one above that previous access. Any DMA cycle or idle cycle in between therefore makes the next processor access nonsequential, including a request re-issued after a stall. A three-state owner machine records who used the port in the previous cycle: `PORT_IDLE` (nobody), `PORT_CPU` (processor access performed) and `PORT_DMA` (DMA enable high). From any state, DMA enable high goes to `PORT_DMA`; otherwise a valid processor request goes to `PORT_CPU`; otherwise the machine goes to `PORT_IDLE`. Reset enters `PORT_IDLE`.

Top module: `tcm_dma_arbiter`

## Requirements
- R1: While `dma_en` is 1, `mem_addr` equals `dma_addr` and `mem_cs` equals `dma_cs`, in the same cycle.
- R2: While `dma_en` is 1, `mem_seq` is 0.
- R3: While `dma_en` is 1 and there is no valid processor request, `cpu_stall` is 0.
- R4: While `dma_en` is 1 and a valid processor request is present, `cpu_stall` is 1 and the processor address does not reach `mem_addr`.
- R5: The first processor access after a DMA cycle drives the processor's address with `mem_cs` 1 and `mem_seq` 0, even when `cpu_seq` is 1.
- R6: A processor access that follows a re-issued access, has `cpu_seq` 1 and an address one above it (modulo 2^AW) gives `mem_seq` 1.
- R7: `mem_seq` is 1 only for a processor access with `cpu_seq` 1, whose previous cycle was a processor access at the address one lower; the first access after an idle cycle is nonsequential.
- R8: A request is valid when `cpu_req` is 1 and `cpu_idle` is 0. With `dma_en` 0 and a valid request, `mem_addr` equals `cpu_addr`, `mem_cs` is 1 and `cpu_stall` is 0; `cpu_stall` equals `dma_en` AND valid at all times.
- R9: With `dma_en` 0 and no valid request, `mem_cs` is 0, `mem_seq` is 0 and `mem_addr` keeps the last address driven by either owner.
- R10: During and right after reset, `cpu_stall`, `mem_cs` and `mem_seq` are 0, `mem_addr` is 0 and the owner state is `PORT_IDLE`, so a first access carrying `cpu_seq` 1 is nonsequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request present |
| cpu_idle | input | 1 | Processor memory controller idle; masks `cpu_req` |
| cpu_seq | input | 1 | Processor's sequential hint request |
| cpu_addr | input | AW | Processor word address |
| dma_en | input | 1 | DMA claims the port this cycle |
| dma_cs | input | 1 | DMA chip-select |
| dma_addr | input | AW | DMA word address |
| mem_addr | output | AW | Address to the memory |
| mem_cs | output | 1 | Chip-select to the memory |
| mem_seq | output | 1 | Sequential hint to the memory |
| cpu_stall | output | 1 | Processor must hold its request |

## Verification
The bench replays a burst that DMA preempts mid-stream: a DMA cycle during processor idle, a nonsequential then sequential processor pair, a stalled third beat, its re-issue and the beat after it. A design that kept the processor's hint across the DMA cycle would show `mem_seq` high on the re-issue, and one that cleared the history too eagerly would leave the following beat nonsequential. Random traffic adds wrapping addresses, non-incrementing addresses with the hint set, idle gaps and DMA cycles with chip-select low; a design that dropped the held address in a quiet cycle, or stalled while the processor was idle, is caught by a reference model in the bench.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;

    // Owner of the port in a given cycle (current grant or previous-cycle state)
    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_CPU  = 2'd1,
        PORT_DMA  = 2'd2
    } port_owner_e;

endpackage

// File: rtl/tcm_arb_fsm.sv
module tcm_arb_fsm
    import tcm_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dma_en,
    input  logic        cpu_valid,
    output port_owner_e grant,
    output port_owner_e prev_owner
);

    port_owner_e state_q;

    // Current-cycle grant: DMA first, then processor, else nobody
    always_comb begin
        if (dma_en)
            grant = PORT_DMA;
        else if (cpu_valid)
            grant = PORT_CPU;
        else
            grant = PORT_IDLE;
    end

    // State register: remembers who owned the port last cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PORT_IDLE;
        else
            state_q <= grant;
    end

    always_comb prev_owner = state_q;

    // R10: state clears on reset and stays idle for the first cycle after it
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (state_q == PORT_IDLE) || rst_n);

    // R2: a DMA cycle always leaves a DMA history behind it
    p_dma_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |=> state_q == PORT_DMA);

endmodule

// File: rtl/tcm_arb_seqgen.sv
module tcm_arb_seqgen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_fire,
    input  logic          prev_was_cpu,
    input  logic          cpu_seq,
    input  logic [AW-1:0] cpu_addr,
    output logic          seq_ok
);

    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] last_cpu_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_cpu_q <= '0;
        else if (cpu_fire)
            last_cpu_q <= cpu_addr;
    end

    // Hint survives only a direct processor-to-processor increment
    always_comb begin
        seq_ok = cpu_fire && cpu_seq && prev_was_cpu &&
                 (cpu_addr == last_cpu_q + ONE);
    end

    // R7: a sequential hint needs a processor access one address lower last cycle
    p_seq_incr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ok |-> ($past(cpu_fire) && (cpu_addr == $past(cpu_addr) + ONE)));

endmodule

// File: rtl/tcm_arb_addr_hold.sv
module tcm_arb_addr_hold #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drive_en,
    input  logic [AW-1:0] drive_addr,
    output logic [AW-1:0] out_addr
);

    logic [AW-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_q <= '0;
        else if (drive_en)
            held_q <= drive_addr;
    end

    always_comb out_addr = drive_en ? drive_addr : held_q;

    // R9: with nobody driving, the address line does not move
    p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> out_addr == $past(out_addr));

endmodule

// File: rtl/tcm_dma_arbiter.sv
module tcm_dma_arbiter
    import tcm_arb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_idle,
    input  logic          cpu_seq,
    input  logic [AW-1:0] cpu_addr,
    input  logic          dma_en,
    input  logic          dma_cs,
    input  logic [AW-1:0] dma_addr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs,
    output logic          mem_seq,
    output logic          cpu_stall
);

    logic          cpu_valid;
    logic          cpu_fire;
    logic          seq_ok;
    logic          drive_en;
    logic [AW-1:0] drive_addr;
    port_owner_e   grant;
    port_owner_e   prev_owner;

    always_comb cpu_valid = cpu_req && !cpu_idle;

    tcm_arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dma_en     (dma_en),
        .cpu_valid  (cpu_valid),
        .grant      (grant),
        .prev_owner (prev_owner)
    );

    always_comb cpu_fire = (grant == PORT_CPU);

    tcm_arb_seqgen #(.AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_fire     (cpu_fire),
        .prev_was_cpu (prev_owner == PORT_CPU),
        .cpu_seq      (cpu_seq),
        .cpu_addr     (cpu_addr),
        .seq_ok       (seq_ok)
    );

    // Output process: one arm per grant
    always_comb begin
        drive_en   = 1'b0;
        drive_addr = cpu_addr;
        mem_cs     = 1'b0;
        mem_seq    = 1'b0;
        cpu_stall  = 1'b0;
        unique case (grant)
            PORT_DMA: begin
                drive_en   = 1'b1;
                drive_addr = dma_addr;
                mem_cs     = dma_cs;
                cpu_stall  = cpu_valid;
            end
            PORT_CPU: begin
                drive_en   = 1'b1;
                drive_addr = cpu_addr;
                mem_cs     = 1'b1;
                mem_seq    = seq_ok;
            end
            PORT_IDLE: begin
                drive_en   = 1'b0;
            end
            default: begin
                drive_en   = 1'b0;
            end
        endcase
    end

    tcm_arb_addr_hold #(.AW(AW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive_en   (drive_en),
        .drive_addr (drive_addr),
        .out_addr   (mem_addr)
    );

    // R1: DMA address and chip-select pass straight through
    p_dma_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> (mem_addr == dma_addr) && (mem_cs == dma_cs));

    // R2: no sequential hint in a DMA cycle
    p_dma_noseq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> !mem_seq);

    // R3: DMA against an idle processor never stalls
    p_no_stall_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && (!cpu_req || cpu_idle)) |-> !cpu_stall);

    // R4: processor request under DMA is stalled
    p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && cpu_req && !cpu_idle) |-> cpu_stall);

    // R5: re-issue after a DMA cycle is nonsequential
    p_reissue_nonseq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dma_en) && !dma_en) |-> !mem_seq);

    // R9: quiet port has chip-select low
    p_quiet_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && (!cpu_req || cpu_idle)) |-> (!mem_cs && !mem_seq));

    // R8: stall only ever with DMA present
    p_stall_needs_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> dma_en);

endmodule

// File: tb/tcm_dma_arbiter_tb.sv
module tcm_dma_arbiter_tb_top;

    localparam int AW = 16;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_idle = 1'b1;
    logic          cpu_seq = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          dma_en = 1'b0;
    logic          dma_cs = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_cs;
    logic          mem_seq;
    logic          cpu_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state: 0 idle, 1 cpu, 2 dma
    int            m_prev = 0;
    logic [AW-1:0] m_last_cpu = '0;
    logic [AW-1:0] m_last_addr = '0;

    always #2 clk = ~clk;

    tcm_dma_arbiter #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_idle(cpu_idle), .cpu_seq(cpu_seq), .cpu_addr(cpu_addr),
        .dma_en(dma_en), .dma_cs(dma_cs), .dma_addr(dma_addr),
        .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_seq(mem_seq), .cpu_stall(cpu_stall)
    );

    function automatic logic f_valid();
        return cpu_req && !cpu_idle;
    endfunction

    function automatic logic [AW-1:0] f_exp_addr();
        if (dma_en) return dma_addr;
        if (f_valid()) return cpu_addr;
        return m_last_addr;
    endfunction

    function automatic logic f_exp_cs();
        return dma_en ? dma_cs : f_valid();
    endfunction

    function automatic logic f_exp_seq();
        return !dma_en && f_valid() && cpu_seq && (m_prev == 1) &&
               (cpu_addr == m_last_cpu + AW'(1));
    endfunction

    function automatic logic f_exp_stall();
        return dma_en && f_valid();
    endfunction

    task automatic check_val(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check_val(tag, "mem_addr",  int'(mem_addr),  int'(f_exp_addr()));
        check_val(tag, "mem_cs",    int'(mem_cs),    int'(f_exp_cs()));
        check_val(tag, "mem_seq",   int'(mem_seq),   int'(f_exp_seq()));
        check_val(tag, "cpu_stall", int'(cpu_stall), int'(f_exp_stall()));
    endtask

    task automatic model_update();
        if (dma_en || f_valid()) m_last_addr = f_exp_addr();
        if (dma_en) m_prev = 2;
        else if (f_valid()) begin
            m_prev = 1;
            m_last_cpu = cpu_addr;
        end else m_prev = 0;
    endtask

    // One port cycle: drive at negedge, check mid-low, advance model at posedge
    task automatic step(logic de, logic dc, logic [AW-1:0] da,
                        logic rq, logic idl, logic sq, logic [AW-1:0] ca, string tag);
        @(negedge clk);
        dma_en = de; dma_cs = dc; dma_addr = da;
        cpu_req = rq; cpu_idle = idl; cpu_seq = sq; cpu_addr = ca;
        #1;
        check_all(tag);
        @(posedge clk);
        model_update();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [AW-1:0] b;
        logic [AW-1:0] nxt;
        logic          held;
        void'($urandom(32'h5eed_0042));
        // R10: outputs during reset
        repeat (3) @(negedge clk);
        #1;
        check_val("R10", "cpu_stall", int'(cpu_stall), 0);
        check_val("R10", "mem_cs",    int'(mem_cs),    0);
        check_val("R10", "mem_seq",   int'(mem_seq),   0);
        check_val("R10", "mem_addr",  int'(mem_addr),  0);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: first access after reset with hint set is nonsequential (addr 1 = 0+1)
        step(0, 0, '0, 1, 0, 1, AW'(1), "R10");
        step(0, 0, '0, 1, 0, 1, AW'(2), "R7");
        // Preempted burst
        b = AW'(16'h0400);
        step(1, 1, AW'(16'h0a00), 0, 1, 0, AW'(2), "R3");      // DMA, processor idle
        step(0, 0, '0, 1, 0, 1, b, "R5");                       // after DMA, nonseq
        step(0, 0, '0, 1, 0, 1, b + AW'(1), "R7");              // seq
        step(1, 1, AW'(16'h0c00), 1, 0, 1, b + AW'(2), "R4");   // stalled
        step(0, 0, '0, 1, 0, 1, b + AW'(2), "R5");              // re-issue, nonseq
        step(0, 0, '0, 1, 0, 1, b + AW'(3), "R6");              // seq again
        step(0, 0, '0, 0, 1, 0, AW'(16'hbeef), "R9");           // quiet, holds b+3
        step(1, 0, AW'(16'h0777), 0, 0, 0, '0, "R1");           // DMA with cs low
        step(0, 0, '0, 0, 0, 1, AW'(16'h1234), "R9");           // holds 0777
        step(0, 0, '0, 1, 1, 1, AW'(16'h1234), "R8");           // idle masks req
        step(0, 0, '0, 1, 0, 1, AW'(16'h1234), "R7");           // after idle, nonseq
        step(0, 0, '0, 1, 0, 1, AW'(16'h1236), "R7");           // not +1, nonseq
        step(0, 0, '0, 1, 0, 1, AW'(16'hffff), "R8");
        step(0, 0, '0, 1, 0, 1, AW'(16'h0000), "R6");           // wrap, seq
        step(1, 1, AW'(16'h0055), 1, 0, 0, AW'(16'h0001), "R2");
        // Constrained random traffic
        nxt  = AW'($urandom);
        held = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            logic de, dc, rq, idl, sq;
            logic [AW-1:0] da, ca;
            string tag;
            de  = ($urandom % 4) == 0;
            dc  = ($urandom % 4) != 0;
            da  = AW'($urandom);
            idl = ($urandom % 8) == 0;
            rq  = held ? 1'b1 : (($urandom % 4) != 0);
            if (held) idl = 1'b0;
            sq  = ($urandom % 5) != 0;
            if (!held) begin
                case ($urandom % 6)
                    0: nxt = AW'($urandom);
                    1: nxt = nxt + AW'(2);
                    default: nxt = nxt + AW'(1);
                endcase
            end
            ca = nxt;
            if (de && rq && !idl) tag = "R4";
            else if (de) tag = "R1";
            else if (rq && !idl && m_prev == 2) tag = "R5";
            else if (rq && !idl) tag = "R7";
            else tag = "R9";
            step(de, dc, da, rq, idl, sq, ca, tag);
            held = de && rq && !idl;
        end
        finish_run();
    end

endmodule